// File: doc/BRIEF.md
# Strap-Addressed I2C Target Front End

This block is the bus-facing half of a register-based monitoring device on a two-wire I2C bus. It brings SCL and SDA into the system clock domain and detects START and STOP conditions. It frames the first byte of each transfer and compares its upper seven bits with the device's own address. That address is not formed from fixed upper bits plus pin values. It is taken from an irregular eight-entry table indexed by three strap pins. The block acknowledges only that address.

On a match, the block reports the transfer direction to a register-access port. During a write, every received byte appears on that port with a one-cycle strobe and is acknowledged. During a read, bytes are fetched from the port one at a time, shifted out MSB first, and the transfer ends when the master does not acknowledge a byte.

A select input can hand the pins to a serial-peripheral engine that lives elsewhere. While it is high, this engine stays idle and keeps SDA released. After every reset, a ready timer holds off all acknowledgements until a programmable number of clock cycles has passed. Standard and fast mode use the same SCL-edge-driven logic.

Top module: `i2c_strap_target`

## Requirements
- R1: The own address follows `strap` (value = strap[2]*4 + strap[1]*2 + strap[0]): 0→0x61, 1→0x62, 2→0x64, 3→0x65, 4→0x2C, 5→0x2D, 6→0x2E, 7→0x2F. A first byte whose upper seven bits equal this address is acknowledged: SDA is pulled low for the ninth SCL pulse.
- R2: A first byte carrying any other address is not acknowledged. The engine then neither drives SDA nor produces any strobe until the next START.
- R3: The general-call address 0x00 and any 10-bit prefix 0b11110xx are never acknowledged, whatever the R/W bit.
- R4: While `spi_sel` is 1, the engine ignores the bus. `sda_oe` is 0 from the next cycle onward, and no strobe is produced.
- R5: For the first READY_CYCLES clock cycles after `rst` is released, `sda_oe` stays 0, so no byte is acknowledged.
- R6: The acknowledge is driven after the eighth SCL falling edge. It is released within a few clock cycles of the ninth SCL falling edge.
- R7: In a write transfer, each received byte (MSB first on the bus) appears on `wr_data`, with `wr_valid` high for exactly one cycle. The byte is acknowledged.
- R8: In a read transfer, `rd_take` pulses for one cycle each time `rd_data` is loaded: once after the address acknowledge, and once after each master ACK. The loaded byte is shifted out MSB first. A master NACK ends the transfer, with SDA released and no further load.
- R9: A repeated START at any bit position restarts address framing. After a STOP, bits sent without a new START are not acknowledged.
- R10: A matched address byte gives a one-cycle `xfer_start` pulse, with `xfer_rd` equal to the R/W bit (1 = read). `xfer_start`, `wr_valid` and `rd_take` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; also restarts the ready delay |
| spi_sel | input | 1 | 1 hands the pins to the SPI engine and idles this engine |
| strap | input | 3 | Address strap pins, index into the address table |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain), 0 releases it |
| xfer_start | output | 1 | One-cycle pulse on an acknowledged address |
| xfer_rd | output | 1 | R/W bit of the current transfer, 1 = read |
| wr_valid | output | 1 | One-cycle strobe for a received write byte |
| wr_data | output | 8 | Received write byte |
| rd_take | output | 1 | One-cycle pulse: `rd_data` was loaded for transmission |
| rd_data | input | 8 | Next byte to send in a read transfer |

## Verification
The bench builds the block with the default two-stage synchronizer and READY_CYCLES set to 400. With that value, a full address byte sent right after reset still falls inside the blocked window, so the ready gating can be observed at the pins. The bench then waits out the delay and uses the same reduced setting for the rest of the run. A bus half-period of eight system clocks leaves room for the synchronizer and edge-detect latency, while the bench still checks that the acknowledge is released shortly after the ninth falling edge.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;
  localparam int BIT_CW = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_WBYTE,
    ST_RBYTE,
    ST_RACK,
    ST_SKIP
  } tgt_state_t;

  // Irregular strap-to-address table.
  function automatic logic [ADDR_W-1:0] strap_to_addr(input logic [2:0] s);
    logic [ADDR_W-1:0] a;
    case (s)
      3'd0:    a = 7'h61;
      3'd1:    a = 7'h62;
      3'd2:    a = 7'h64;
      3'd3:    a = 7'h65;
      3'd4:    a = 7'h2C;
      3'd5:    a = 7'h2D;
      3'd6:    a = 7'h2E;
      default: a = 7'h2F;
    endcase
    return a;
  endfunction

  // General call and 10-bit prefixes are never claimed.
  function automatic logic addr_reserved(input logic [ADDR_W-1:0] a);
    return (a == '0) || (a[ADDR_W-1:ADDR_W-5] == 5'b11110);
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] synced;
  logic [LINES-1:0] prev;

  assign raw = {sda_i, scl_i};

  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], raw[g]};
      end
      assign synced[g] = chain[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= '1;
    else     prev <= synced;
  end

  assign sda_s     = synced[1];
  assign scl_rise  = synced[0] & ~prev[0];
  assign scl_fall  = ~synced[0] & prev[0];
  assign start_det = synced[0] & prev[0] & prev[1] & ~synced[1];
  assign stop_det  = synced[0] & prev[0] & ~prev[1] & synced[1];

endmodule

// File: rtl/i2c_strap_addr.sv
module i2c_strap_addr
  import i2c_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        strap,
  output logic [ADDR_W-1:0] own_addr
);

  always_ff @(posedge clk) begin
    if (rst) own_addr <= strap_to_addr(3'd0);
    else     own_addr <= strap_to_addr(strap);
  end

endmodule

// File: rtl/i2c_ready_timer.sv
module i2c_ready_timer #(
  parameter int READY_CYCLES = 12500
) (
  input  logic clk,
  input  logic rst,
  output logic ready
);

  localparam int CW = $clog2(READY_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      cnt <= cnt + 1'b1;
      if (cnt == CW'(READY_CYCLES - 1)) ready <= 1'b1;
    end
  end

endmodule

// File: rtl/i2c_strap_target.sv
module i2c_strap_target
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int READY_CYCLES = 12500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sel,
  input  logic [2:0]        strap,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              xfer_start,
  output logic              xfer_rd,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_take,
  input  logic [BYTE_W-1:0] rd_data
);

  localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W - 1);

  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [ADDR_W-1:0] own_addr;
  logic              ready;

  tgt_state_t        state;
  logic [BIT_CW-1:0] bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] sh_next;
  logic              ack_on;
  logic              rd_mode;
  logic              m_ack;
  logic              addr_hit;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_strap_addr u_addr (
    .clk      (clk),
    .rst      (rst),
    .strap    (strap),
    .own_addr (own_addr)
  );

  i2c_ready_timer #(.READY_CYCLES(READY_CYCLES)) u_ready (
    .clk   (clk),
    .rst   (rst),
    .ready (ready)
  );

  assign sh_next  = {shreg[BYTE_W-2:0], sda_s};
  assign addr_hit = ready
                  && (sh_next[BYTE_W-1:1] == own_addr)
                  && !addr_reserved(sh_next[BYTE_W-1:1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      bit_cnt    <= '0;
      shreg      <= '0;
      ack_on     <= 1'b0;
      rd_mode    <= 1'b0;
      m_ack      <= 1'b0;
      sda_oe     <= 1'b0;
      xfer_start <= 1'b0;
      xfer_rd    <= 1'b0;
      wr_valid   <= 1'b0;
      wr_data    <= '0;
      rd_take    <= 1'b0;
    end else begin
      xfer_start <= 1'b0;
      wr_valid   <= 1'b0;
      rd_take    <= 1'b0;
      if (spi_sel) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: if (scl_rise) begin
            shreg   <= sh_next;
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) begin
              if (addr_hit) begin
                xfer_start <= 1'b1;
                xfer_rd    <= sh_next[0];
                rd_mode    <= sh_next[0];
                ack_on     <= 1'b0;
                state      <= ST_ACK;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_ACK: if (scl_fall) begin
            if (!ack_on) begin
              ack_on <= 1'b1;
              sda_oe <= 1'b1;
            end else begin
              ack_on  <= 1'b0;
              bit_cnt <= '0;
              if (rd_mode) begin
                shreg   <= rd_data;
                rd_take <= 1'b1;
                sda_oe  <= ~rd_data[BYTE_W-1];
                state   <= ST_RBYTE;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_WBYTE;
              end
            end
          end
          ST_WBYTE: if (scl_rise) begin
            shreg   <= sh_next;
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) begin
              wr_valid <= 1'b1;
              wr_data  <= sh_next;
              ack_on   <= 1'b0;
              state    <= ST_ACK;
            end
          end
          ST_RBYTE: if (scl_fall) begin
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) begin
              sda_oe <= 1'b0;
              state  <= ST_RACK;
            end else begin
              shreg  <= {shreg[BYTE_W-2:0], 1'b0};
              sda_oe <= ~shreg[BYTE_W-2];
            end
          end
          ST_RACK: begin
            if (scl_rise) m_ack <= ~sda_s;
            if (scl_fall) begin
              if (m_ack) begin
                shreg   <= rd_data;
                rd_take <= 1'b1;
                sda_oe  <= ~rd_data[BYTE_W-1];
                bit_cnt <= '0;
                state   <= ST_RBYTE;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_SKIP: sda_oe <= 1'b0;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_strap_target_chk.sv
module i2c_strap_target_chk #(
  parameter int READY_CYCLES = 12500
) (
  input logic clk,
  input logic rst,
  input logic spi_sel,
  input logic sda_oe,
  input logic xfer_start,
  input logic wr_valid,
  input logic rd_take
);

  logic [31:0] age;

  always_ff @(posedge clk) begin
    if (rst)                age <= '0;
    else if (age != '1)     age <= age + 1'b1;
  end

  AST_SPI_RELEASE: assert property (@(posedge clk) disable iff (rst)
    spi_sel |=> !sda_oe); // R4

  AST_READY_GATE: assert property (@(posedge clk) disable iff (rst)
    (age < 32'(READY_CYCLES)) |-> !sda_oe); // R5

  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !wr_valid); // R7

  AST_TAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rd_take |=> !rd_take); // R8

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    xfer_start |=> !xfer_start); // R10

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({xfer_start, wr_valid, rd_take})); // R10

endmodule

bind i2c_strap_target i2c_strap_target_chk #(.READY_CYCLES(READY_CYCLES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .spi_sel    (spi_sel),
  .sda_oe     (sda_oe),
  .xfer_start (xfer_start),
  .wr_valid   (wr_valid),
  .rd_take    (rd_take)
);

// File: tb/sim_i2c_strap_target.sv
`timescale 1ns/1ps
module sim_i2c_strap_target;

  localparam int READY = 400;
  localparam int HP    = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       spi_sel = 1'b0;
  logic [2:0] strap = 3'd0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [7:0] rd_data;
  logic       sda_oe, xfer_start, xfer_rd, wr_valid, rd_take;
  logic [7:0] wr_data;
  wire        sda_bus = sda_m & ~sda_oe;

  int n_tests = 0;
  int n_fail  = 0;
  int wr_n    = 0;
  int xs_n    = 0;
  int rd_idx  = 0;
  logic       last_rd = 1'b0;
  logic [7:0] wr_log [0:255];
  logic [7:0] exp_w  [0:3];

  always #10 clk = ~clk;

  i2c_strap_target #(.SYNC_STAGES(2), .READY_CYCLES(READY)) u0 (
    .clk(clk), .rst(rst), .spi_sel(spi_sel), .strap(strap),
    .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .xfer_start(xfer_start), .xfer_rd(xfer_rd),
    .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_take(rd_take), .rd_data(rd_data)
  );

  function automatic logic [6:0] exp_addr(input logic [2:0] s);
    case (s)
      3'd0: return 7'h61; 3'd1: return 7'h62;
      3'd2: return 7'h64; 3'd3: return 7'h65;
      3'd4: return 7'h2C; 3'd5: return 7'h2D;
      3'd6: return 7'h2E; default: return 7'h2F;
    endcase
  endfunction

  function automatic logic [7:0] rd_pattern(input int i);
    return 8'((i * 37 + 11) & 8'hFF);
  endfunction

  assign rd_data = rd_pattern(rd_idx);

  always @(negedge clk) begin
    if (!rst) begin
      if (wr_valid) begin wr_log[wr_n[7:0]] = wr_data; wr_n++; end
      if (xfer_start) begin xs_n++; last_rd = xfer_rd; end
      if (rd_take) rd_idx++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hp();
    repeat (HP) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp(); sda_m = 1'b0; hp();
    scl_m = 1'b0; repeat (2) @(negedge clk);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hp(); scl_m = 1'b1; hp(); sda_m = 1'b1; hp();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sda_m = b[7-i]; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic get_ack(output bit ack, output bit oe_after);
    sda_m = 1'b1; hp(); scl_m = 1'b1;
    repeat (HP/2) @(negedge clk);
    ack = (sda_bus == 1'b0);
    repeat (HP/2) @(negedge clk);
    scl_m = 1'b0;
    repeat (6) @(negedge clk);
    oe_after = sda_oe;
  endtask

  task automatic read_byte(output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hp(); scl_m = 1'b1;
      repeat (HP/2) @(negedge clk);
      b[7-i] = sda_bus;
      repeat (HP/2) @(negedge clk);
      scl_m = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic send_mack(input bit nack);
    sda_m = nack; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_xfer(input logic [6:0] addr, input bit rw, input int nb,
                         input bit exp_ack, input string tag, input bit do_stop);
    int wr0, xs0, rd0;
    bit ack, rel;
    logic [7:0] b;
    wr0 = wr_n; xs0 = xs_n; rd0 = rd_idx;
    bus_start();
    send_bits({addr, rw}, 8);
    get_ack(ack, rel);
    chk(ack == exp_ack, tag, int'(ack), int'(exp_ack));
    if (ack && !rw) begin
      for (int i = 0; i < nb; i++) begin
        exp_w[i] = 8'($urandom);
        send_bits(exp_w[i], 8);
        get_ack(ack, rel);
        chk(ack, "R7 data ack", int'(ack), 1);
        chk(!rel, "R6 ack release", int'(rel), 0);
      end
      chk(wr_n - wr0 == nb, "R7 byte count", wr_n - wr0, nb);
      for (int i = 0; i < nb; i++)
        chk(wr_log[8'(wr0 + i)] == exp_w[i], "R7 data", int'(wr_log[8'(wr0 + i)]), int'(exp_w[i]));
    end else if (ack && rw) begin
      for (int i = 0; i < nb; i++) begin
        read_byte(b);
        chk(b == rd_pattern(rd0 + i), "R8 read data", int'(b), int'(rd_pattern(rd0 + i)));
        send_mack(i == nb - 1);
      end
      repeat (4) @(negedge clk);
      chk(sda_oe == 1'b0, "R8 released after NACK", int'(sda_oe), 0);
      chk(rd_idx - rd0 == nb, "R8 take count", rd_idx - rd0, nb);
    end else begin
      send_bits(8'h3C, 8);
      chk(wr_n == wr0 && rd_idx == rd0, {tag, " no strobe"}, wr_n - wr0, 0);
    end
    if (do_stop) bus_stop();
    chk(xs_n - xs0 == (exp_ack ? 1 : 0), "R10 start count", xs_n - xs0, exp_ack ? 1 : 0);
    if (exp_ack) chk(last_rd == rw, "R10 direction", int'(last_rd), int'(rw));
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [6:0] own, a;
    bit rw, ack, rel;
    int nb;
    void'($urandom(32'h5EED));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    chk(sda_oe == 0 && wr_valid == 0 && xfer_start == 0 && rd_take == 0,
        "reset outputs idle", int'({sda_oe, wr_valid, xfer_start, rd_take}), 0);

    // R5: own address inside the ready window is not acknowledged
    do_xfer(7'h61, 1'b0, 1, 1'b0, "R5 not ready", 1'b1);
    repeat (READY) @(negedge clk);

    // R1: every strap value
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s); repeat (3) @(negedge clk);
      do_xfer(exp_addr(3'(s)), 1'b0, 1, 1'b1, "R1 strap ack", 1'b1);
    end

    // R2: neighbours of the own address
    strap = 3'd0; repeat (3) @(negedge clk);
    do_xfer(7'h62, 1'b0, 1, 1'b0, "R2 foreign", 1'b1);
    do_xfer(7'h2C, 1'b1, 1, 1'b0, "R2 foreign", 1'b1);

    // R3: general call and 10-bit prefix
    do_xfer(7'h00, 1'b0, 1, 1'b0, "R3 general call", 1'b1);
    do_xfer(7'h78, 1'b0, 1, 1'b0, "R3 ten-bit", 1'b1);
    do_xfer(7'h7B, 1'b1, 1, 1'b0, "R3 ten-bit", 1'b1);

    // R4: SPI selected
    spi_sel = 1'b1;
    do_xfer(7'h61, 1'b0, 1, 1'b0, "R4 spi", 1'b1);
    spi_sel = 1'b0;
    repeat (3) @(negedge clk);

    // R9: repeated START mid-byte, then write, then repeated START read
    bus_start();
    send_bits(8'hA5, 4);
    do_xfer(7'h61, 1'b0, 2, 1'b1, "R9 restart mid-byte", 1'b0);
    do_xfer(7'h61, 1'b1, 2, 1'b1, "R9 restart read", 1'b1);

    // R9: after STOP, bits without START are ignored
    scl_m = 1'b0; hp();
    send_bits({7'h61, 1'b0}, 8);
    get_ack(ack, rel);
    chk(!ack, "R9 idle after stop", int'(ack), 0);
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp();

    // Random mix
    for (int k = 0; k < 24; k++) begin
      strap = 3'($urandom);
      repeat (3) @(negedge clk);
      own = exp_addr(strap);
      a  = ($urandom % 2 == 0) ? own : 7'($urandom);
      rw = 1'($urandom);
      nb = 1 + int'($urandom % 4);
      do_xfer(a, rw, nb, a == own, "R1/R2 random", 1'b1);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule